// File: doc/BRIEF.md
# Event timer comparator channel

This block is one comparator channel of a multi-channel event timer. A shared 64-bit main counter runs outside the block and reaches it on `count_i`. Software programs a target through a small register write port. When the counter reaches that target and the global run input is high, the channel emits a one-cycle pulse on `fire_o`. In periodic mode the channel then advances its own target by a stored period. In one-shot mode it disarms.

A 32-bit compatibility mode compares only the low half of the target. The channel extends that half to a full 64-bit match point ahead of the counter. In one-shot operation it adds an extra pulse at the counter's next 32-bit rollover when the real match lies beyond it. A comparator write in periodic mode always loads the period. It also moves the visible comparator only when a self-clearing set-value bit is armed.

The match point is worked out again one cycle after any config or comparator write made while running, and one cycle after `run_i` rises. The calculation uses the counter value present in that cycle.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset `fire_o` is 0, `cmp_o` is all ones and `cfg_o` reads 5'h18. The config bits are: [0] periodic, [1] 32-bit mode, [2] set-value, [3] periodic-capable (reads 1), [4] 64-bit-capable (reads 1).
- R2: In 64-bit one-shot mode the channel pulses once when `count_i` equals the comparator, then stays quiet.
- R3: A comparator write (`wr_sel_i`=1) in periodic mode loads the period. It loads the comparator only when set-value is 1. Any accepted comparator write clears set-value.
- R4: In periodic mode with a nonzero period, a pulse occurs every period. After each pulse `cmp_o` shows the next match.
- R5: If the counter has jumped past the match, the channel gives one pulse. It then adds the period until the match is ahead of the counter, with no further pulse on the way.
- R6: Periodic mode with a zero period behaves as one-shot.
- R7: In 32-bit mode the match is the counter's upper half joined to the comparator's low half. If that value is below the counter, 2^32 is added.
- R8: In 32-bit one-shot mode, if the extended match lies beyond the counter's next 32-bit rollover, the channel pulses at the rollover and again at the match.
- R9: In 32-bit mode, a write of only the upper comparator half is ignored. A 64-bit write keeps only its low 32 bits. Entering the mode clears the upper halves of both comparator and period.
- R10: While `run_i` is 0 no pulse occurs and writes do not arm the channel. A rising `run_i` arms the channel from the stored comparator.
- R11: `fire_o` is high for exactly one cycle per event. It is seen in the cycle that follows the clock edge at which `count_i` met the match.
- R12: In 32-bit periodic mode the visible comparator holds only the low 32 bits of the advanced match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| count_i | input | 64 | Shared main counter value |
| run_i | input | 1 | Global enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | 0 selects config, 1 selects comparator |
| wr_hi_i | input | 1 | Half write targets the upper 32 bits |
| wr_wide_i | input | 1 | Full 64-bit write |
| wr_data_i | input | 64 | Write data; half writes use bits [31:0] |
| cfg_o | output | 5 | Config readback |
| cmp_o | output | 64 | Visible comparator |
| fire_o | output | 1 | One-cycle event pulse |

## Verification
The bench steers the counter straight through 32-bit rollovers and checks both one-shot pulses. A design that skipped the rollover pulse would fire once. One that failed to add 2^32 would fire at once or never. A counter jump past a periodic match tests catch-up: a channel that fired on every step of the catch-up would give a burst of pulses, and one that did not catch up would miss the next period. The bench also checks that a comparator write lands in the period and not the comparator when set-value is clear, and that an upper-half write in 32-bit mode leaves the comparator unchanged. Finally, stopped-run writes are checked: arming without `run_i` would give a pulse while stopped.

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel #(
  parameter int CNT_W = 64,
  parameter int LOW_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count_i,
  input  logic             run_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic             wr_hi_i,
  input  logic             wr_wide_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [4:0]       cfg_o,
  output logic [CNT_W-1:0] cmp_o,
  output logic             fire_o
);
  localparam logic [CNT_W-1:0] STEP     = CNT_W'(1) << LOW_W;
  localparam logic [CNT_W-1:0] LOW_ONES = STEP - CNT_W'(1);
  localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

  logic             periodic_q, mode32_q, setval_q;
  logic [CNT_W-1:0] cmp_q, period_q, target_q, final_q;
  logic             armed_q, wrap_q, catch_q, rearm_q, run_q, fire_q;

  logic             cfg_wr, cmp_wr, per_on;
  logic [CNT_W-1:0] ext, eff, nwrap, diff, stepped;
  logic             wrap_need, match;

  function automatic logic [CNT_W-1:0] put(input logic [CNT_W-1:0] old);
    if (mode32_q)       put = wr_data_i & LOW_ONES;
    else if (wr_wide_i) put = wr_data_i;
    else if (wr_hi_i)   put = {wr_data_i[LOW_W-1:0], old[LOW_W-1:0]};
    else                put = {old[CNT_W-1:LOW_W], wr_data_i[LOW_W-1:0]};
  endfunction

  assign cfg_wr  = wr_en_i && !wr_sel_i && (!wr_hi_i || wr_wide_i);
  assign cmp_wr  = wr_en_i && wr_sel_i && !(mode32_q && wr_hi_i && !wr_wide_i);
  assign per_on  = periodic_q && (period_q != '0);

  assign ext     = {count_i[CNT_W-1:LOW_W], cmp_q[LOW_W-1:0]};
  assign eff     = !mode32_q ? cmp_q : ((ext < count_i) ? ext + STEP : ext);
  assign nwrap   = (count_i | LOW_ONES) + ONE;
  assign wrap_need = mode32_q && !periodic_q && (eff > nwrap);

  assign diff    = count_i - target_q;
  assign stepped = target_q + period_q;
  assign match   = armed_q && run_i && !rearm_q && !catch_q && !diff[CNT_W-1];

  assign cfg_o  = {1'b1, 1'b1, setval_q, mode32_q, periodic_q};
  assign cmp_o  = cmp_q;
  assign fire_o = fire_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      periodic_q <= 1'b0;
      mode32_q   <= 1'b0;
      setval_q   <= 1'b0;
      cmp_q      <= '1;
      period_q   <= '0;
      target_q   <= '0;
      final_q    <= '0;
      armed_q    <= 1'b0;
      wrap_q     <= 1'b0;
      catch_q    <= 1'b0;
      rearm_q    <= 1'b0;
      run_q      <= 1'b0;
      fire_q     <= 1'b0;
    end else begin
      fire_q  <= match;
      run_q   <= run_i;
      rearm_q <= run_i && (cfg_wr || cmp_wr || !run_q);

      if (rearm_q) begin
        target_q <= wrap_need ? nwrap : eff;
        final_q  <= eff;
        wrap_q   <= wrap_need;
        armed_q  <= 1'b1;
        catch_q  <= 1'b0;
      end else if (match) begin
        if (per_on) begin
          target_q <= stepped;
          cmp_q    <= mode32_q ? (stepped & LOW_ONES) : stepped;
          catch_q  <= 1'b1;
        end else if (wrap_q) begin
          wrap_q   <= 1'b0;
          target_q <= final_q;
        end else begin
          armed_q  <= 1'b0;
        end
      end else if (catch_q) begin
        if (diff[CNT_W-1]) begin
          catch_q <= 1'b0;
        end else begin
          target_q <= stepped;
          cmp_q    <= mode32_q ? (stepped & LOW_ONES) : stepped;
        end
      end

      if (cfg_wr) begin
        periodic_q <= wr_data_i[0];
        mode32_q   <= wr_data_i[1];
        setval_q   <= wr_data_i[2];
        if (wr_data_i[1]) begin
          cmp_q    <= cmp_q & LOW_ONES;
          period_q <= period_q & LOW_ONES;
        end
      end

      if (cmp_wr) begin
        if (!periodic_q || setval_q) cmp_q <= put(cmp_q);
        if (periodic_q) period_q <= put(period_q);
        setval_q <= 1'b0;
      end

      if (!run_i) begin
        armed_q <= 1'b0;
        catch_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/evt_cmp_channel_chk.sv
module evt_cmp_channel_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        run_i,
  input logic        wr_en_i,
  input logic        wr_sel_i,
  input logic        wr_hi_i,
  input logic        wr_wide_i,
  input logic [4:0]  cfg_o,
  input logic [63:0] cmp_o,
  input logic        fire_o
);
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !fire_o);

  a_r10_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> !fire_o);

  a_r3_setval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i && !(cfg_o[1] && wr_hi_i && !wr_wide_i)) |=> !cfg_o[2]);

  a_r9_upper_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_sel_i && cfg_o[1] && !cfg_o[0] && wr_hi_i && !wr_wide_i) |=> $stable(cmp_o));

  a_r9_short_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_o[1] |-> (cmp_o[63:32] == 32'h0));
endmodule

bind evt_cmp_channel evt_cmp_channel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .run_i(run_i), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
  .wr_hi_i(wr_hi_i), .wr_wide_i(wr_wide_i), .cfg_o(cfg_o), .cmp_o(cmp_o), .fire_o(fire_o)
);

// File: tb/evt_cmp_channel_tb.sv
module evt_cmp_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] count_i = '0;
  logic        run_i = 1'b0;
  logic        wr_en_i = 1'b0, wr_sel_i = 1'b0, wr_hi_i = 1'b0, wr_wide_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic [4:0]  cfg_o;
  logic [63:0] cmp_o;
  logic        fire_o;

  int errors = 0, checks = 0, nfire = 0, doubles = 0;
  logic [63:0] fire_at [8];
  logic prev = 1'b0;

  always #10 clk = ~clk;

  evt_cmp_channel dut_i (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .run_i(run_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_hi_i(wr_hi_i), .wr_wide_i(wr_wide_i),
    .wr_data_i(wr_data_i), .cfg_o(cfg_o), .cmp_o(cmp_o), .fire_o(fire_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic sweep(input int n, input bit inc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (fire_o) begin
        if (nfire < 8) fire_at[nfire] = count_i;
        nfire++;
        if (prev) doubles++;
      end
      prev = fire_o;
      if (inc) count_i = count_i + 64'd1;
    end
  endtask

  task automatic wr(input bit sel, input bit hi, input bit wide, input logic [63:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_sel_i = sel; wr_hi_i = hi; wr_wide_i = wide; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
    sweep(3, 1'b0);
  endtask

  task automatic t_reset;
    chk("R1 fire", {63'h0, fire_o}, 64'h0);
    chk("R1 cmp", cmp_o, '1);
    chk("R1 cfg", {59'h0, cfg_o}, 64'h18);
  endtask

  task automatic t_oneshot64;
    count_i = 64'd100;
    wr(1, 0, 1, 64'd120);
    nfire = 0;
    sweep(100, 1'b1);
    chk("R2 count", nfire, 1);
    chk("R2 at", fire_at[0], 64'd120);
  endtask

  task automatic t_periodic;
    count_i = 64'd200;
    wr(0, 0, 1, 64'h5);
    wr(1, 0, 1, 64'd300);
    chk("R3 setval cleared", {63'h0, cfg_o[2]}, 64'h0);
    wr(1, 0, 1, 64'd50);
    chk("R3 cmp kept", cmp_o, 64'd300);
    nfire = 0;
    sweep(260, 1'b1);
    chk("R4 count", nfire, 4);
    chk("R4 first", fire_at[0], 64'd300);
    chk("R4 second", fire_at[1], 64'd350);
    chk("R4 fourth", fire_at[3], 64'd450);
    chk("R4 next cmp", cmp_o, 64'd500);
  endtask

  task automatic t_zero_period;
    count_i = 64'd450;
    wr(0, 0, 1, 64'h0);
    wr(1, 0, 1, 64'd500);
    wr(0, 0, 1, 64'h1);
    wr(1, 0, 1, 64'd0);
    nfire = 0;
    sweep(150, 1'b1);
    chk("R6 count", nfire, 1);
    chk("R6 at", fire_at[0], 64'd500);
    chk("R6 cmp", cmp_o, 64'd500);
  endtask

  task automatic t_mode32_writes;
    count_i = 64'd0;
    wr(0, 0, 1, 64'h0);
    wr(1, 0, 1, 64'h1_0000_0040);
    wr(0, 0, 1, 64'h2);
    chk("R9 enter truncates", cmp_o, 64'h40);
    wr(1, 1, 0, 64'hDEAD);
    chk("R9 upper ignored", cmp_o, 64'h40);
    wr(1, 0, 1, 64'hABCD_0000_0000_0055);
    chk("R9 wide low only", cmp_o, 64'h55);
  endtask

  task automatic t_wrap_oneshot;
    count_i = 64'h5_FFFF_FFF0;
    wr(1, 0, 0, 64'h10);
    nfire = 0;
    sweep(48, 1'b1);
    chk("R8 count", nfire, 2);
    chk("R8 rollover", fire_at[0], 64'h6_0000_0000);
    chk("R7 extended match", fire_at[1], 64'h6_0000_0010);
  endtask

  task automatic t_nowrap32;
    count_i = 64'h7_0000_0000;
    wr(1, 0, 0, 64'h30);
    nfire = 0;
    sweep(64, 1'b1);
    chk("R7 count", nfire, 1);
    chk("R7 at", fire_at[0], 64'h7_0000_0030);
  endtask

  task automatic t_periodic32;
    count_i = 64'h1_FFFF_FF00;
    wr(0, 0, 1, 64'h7);
    wr(1, 0, 0, 64'hFFFF_FFF0);
    wr(1, 0, 0, 64'h40);
    nfire = 0;
    sweep(320, 1'b1);
    chk("R12 count", nfire, 2);
    chk("R12 first", fire_at[0], 64'h1_FFFF_FFF0);
    chk("R12 second", fire_at[1], 64'h2_0000_0030);
    chk("R12 trunc cmp", cmp_o, 64'h70);
  endtask

  task automatic t_run_gate;
    run_i = 1'b0;
    count_i = 64'd900;
    wr(0, 0, 1, 64'h0);
    wr(1, 0, 1, 64'd1000);
    nfire = 0;
    sweep(200, 1'b1);
    chk("R10 stopped", nfire, 0);
    count_i = 64'd1100;
    wr(1, 0, 1, 64'd1200);
    run_i = 1'b1;
    nfire = 0;
    sweep(150, 1'b1);
    chk("R10 rearm count", nfire, 1);
    chk("R10 rearm at", fire_at[0], 64'd1200);
  endtask

  task automatic t_catchup;
    count_i = 64'd980;
    wr(0, 0, 1, 64'h5);
    wr(1, 0, 1, 64'd1000);
    wr(1, 0, 1, 64'd10);
    nfire = 0;
    sweep(10, 1'b1);
    count_i = 64'd1035;
    sweep(6, 1'b0);
    chk("R5 one pulse", nfire, 1);
    chk("R5 caught up", cmp_o, 64'd1040);
    nfire = 0;
    sweep(10, 1'b1);
    chk("R5 next count", nfire, 1);
    chk("R5 next at", fire_at[0], 64'd1040);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_i = 1'b1;
    sweep(3, 1'b0);
    t_oneshot64();
    t_periodic();
    t_zero_period();
    t_mode32_writes();
    t_wrap_oneshot();
    t_nowrap32();
    t_periodic32();
    t_run_gate();
    t_catchup();
    chk("R11 single cycle", doubles, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule